// File: doc/BRIEF.md
# Cache Block Fill Controller with Optional Bank Interleaving

This block loads one cache block from main memory when the cache misses. The cache presents a block address. The controller then sends word addresses one per cycle over a bus that is one word wide. It collects the returned words into an internal block register and raises a one-cycle completion pulse once every word of the block is present. The cache may use the block as soon as that pulse appears. It does not need to wait until the words have been copied into its own array.

Every memory bank has a fixed access time. A bank receives an address in one cycle, works for `ACCESS_LAT` cycles and then returns the word in the next cycle. In that same cycle it can accept a new address. In single-bank mode every word goes to one bank, so only one access is outstanding at a time. In interleaved mode word *i* is served by bank *i* mod `BANKS`, so up to `BANKS` accesses overlap. The mode is taken from an input at the moment a request is accepted.

Top module: `fill_ctrl`

## Requirements
- R1: During reset and in the first cycle after reset, `busy`, `done` and `mem_avalid` are all 0.
- R2: A request is accepted when `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle, and the first word address appears in that same next cycle.
- R3: Each accepted fill sends exactly `WORDS` (8) word addresses. They go in ascending word order, and each one is `{block, word}`, with the 3-bit word index in the low bits of `mem_addr`.
- R4: In single-bank mode (`req_interleave`=0 at acceptance), consecutive addresses are exactly `ACCESS_LAT`+1 (21) cycles apart.
- R5: In interleaved mode (`req_interleave`=1), word *i* uses bank *i* mod 4. Words 0 to 3 are sent in four consecutive cycles, and word *i*+4 is sent exactly 21 cycles after word *i*.
- R6: Returned words are stored in arrival order. The *k*-th word returned during a fill appears in `blk_data[k*DATA_W +: DATA_W]`.
- R7: `done` is 1 for exactly one cycle, in the cycle after the eighth word is captured. `busy` is 0 in that cycle, and a request made in that cycle is accepted.
- R8: A request made while `busy` is 1 is ignored. The address sequence and the block being filled do not change.
- R9: The mode input is sampled only when a request is accepted. Changing it during a fill has no effect on the timing.
- R10: Measured from the cycle in which a request is accepted, `done` appears 170 cycles later in single-bank mode and 47 cycles later in interleaved mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request |
| req_blk | input | BLK_W | Block address of the request |
| req_interleave | input | 1 | 1 = interleaved banks, 0 = single bank |
| busy | output | 1 | A fill is in progress |
| mem_avalid | output | 1 | A word address is being sent this cycle |
| mem_addr | output | BLK_W+3 | Word address: {block, word index} |
| mem_rvalid | input | 1 | A data word is being returned this cycle |
| mem_rdata | input | DATA_W | Returned data word |
| blk_data | output | WORDS*DATA_W | Collected block, word 0 in the low bits |
| done | output | 1 | One-cycle pulse: the block is complete |

## Verification
The assertions assume that memory is well behaved. Each word comes back exactly `ACCESS_LAT`+1 cycles after its address, in the order the addresses were sent, and `mem_rvalid` is never raised unless a word is outstanding. The bench's memory model follows exactly this rule. It queues each observed address and drives its data in the cycle it is due. Requests are therefore the only stimulus that is free to vary. They include requests during a fill, mode flips during a fill, and a new request in the completion cycle.

// File: rtl/fill_pkg.sv
package fill_pkg;
    localparam int unsigned DEF_BLK_W   = 20;
    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_WORDS   = 8;
    localparam int unsigned DEF_BANKS   = 4;
    localparam int unsigned DEF_LAT     = 20;

    typedef enum logic {
        MODE_ONE_BANK = 1'b0,
        MODE_SPREAD   = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/fill_bank_timer.sv
module fill_bank_timer #(
    parameter int unsigned LAT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic free_o
);
    localparam int unsigned CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CNT_W'(LAT);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign free_o = (cnt_q == '0);

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (cnt_q == '0));
endmodule

// File: rtl/fill_seq.sv
module fill_seq #(
    parameter int unsigned BLK_W = 20,
    parameter int unsigned WORDS = 8,
    parameter int unsigned BANKS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid_i,
    input  logic [BLK_W-1:0]                req_blk_i,
    input  logic                            req_ilv_i,
    input  logic [BANKS-1:0]                bank_free_i,
    input  logic                            finish_i,
    output logic                            busy_o,
    output logic                            mem_avalid_o,
    output logic [BLK_W+$clog2(WORDS)-1:0]  mem_addr_o,
    output logic [BANKS-1:0]                bank_start_o
);
    import fill_pkg::*;

    localparam int unsigned IDX_W  = $clog2(WORDS);
    localparam int unsigned BANK_W = $clog2(BANKS);

    typedef struct packed {
        logic             busy;
        fill_mode_e       mode;
        logic [BLK_W-1:0] blk;
        logic [IDX_W:0]   idx;
    } seq_t;

    seq_t             d, q;
    logic [BANK_W-1:0] sel;
    logic             issue;

    always_comb begin
        d     = q;
        sel   = (q.mode == MODE_SPREAD) ? q.idx[BANK_W-1:0] : '0;
        issue = q.busy && (q.idx < (IDX_W+1)'(WORDS)) && bank_free_i[sel];

        if (req_valid_i && !q.busy) begin
            d.busy = 1'b1;
            d.mode = req_ilv_i ? MODE_SPREAD : MODE_ONE_BANK;
            d.blk  = req_blk_i;
            d.idx  = '0;
        end
        if (issue) begin
            d.idx = q.idx + 1'b1;
        end
        if (finish_i) begin
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o       = q.busy;
    assign mem_avalid_o = issue;
    assign mem_addr_o   = {q.blk, q.idx[IDX_W-1:0]};
    assign bank_start_o = issue ? (BANKS'(1) << sel) : '0;

    // R8
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && req_valid_i && !finish_i) |=>
            (q.blk == $past(q.blk) && q.mode == $past(q.mode) && q.busy));

    // R7
    all_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |-> (q.idx == (IDX_W+1)'(WORDS)));

    // R4
    single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && q.mode == MODE_ONE_BANK) |=> !issue);
endmodule

// File: rtl/fill_collect.sv
module fill_collect #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rvalid_i,
    input  logic [DATA_W-1:0]       rdata_i,
    output logic                    last_o,
    output logic [WORDS*DATA_W-1:0] blk_data_o,
    output logic                    done_o
);
    localparam int unsigned IDX_W = $clog2(WORDS);

    typedef struct packed {
        logic [IDX_W-1:0]             rcnt;
        logic                         done;
        logic [WORDS-1:0][DATA_W-1:0] words;
    } col_t;

    col_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        last_o = rvalid_i && (q.rcnt == IDX_W'(WORDS - 1));
        if (rvalid_i) begin
            d.words[q.rcnt] = rdata_i;
            d.rcnt          = q.rcnt + 1'b1;
        end
        if (last_o) begin
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign blk_data_o = q.words;
    assign done_o     = q.done;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl #(
    parameter int unsigned BLK_W      = fill_pkg::DEF_BLK_W,
    parameter int unsigned DATA_W     = fill_pkg::DEF_DATA_W,
    parameter int unsigned WORDS      = fill_pkg::DEF_WORDS,
    parameter int unsigned BANKS      = fill_pkg::DEF_BANKS,
    parameter int unsigned ACCESS_LAT = fill_pkg::DEF_LAT
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [BLK_W-1:0]                req_blk,
    input  logic                            req_interleave,
    output logic                            busy,
    output logic                            mem_avalid,
    output logic [BLK_W+$clog2(WORDS)-1:0]  mem_addr,
    input  logic                            mem_rvalid,
    input  logic [DATA_W-1:0]               mem_rdata,
    output logic [WORDS*DATA_W-1:0]         blk_data,
    output logic                            done
);
    logic [BANKS-1:0] bank_free;
    logic [BANKS-1:0] bank_start;
    logic             finish;

    fill_seq #(.BLK_W(BLK_W), .WORDS(WORDS), .BANKS(BANKS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_blk_i    (req_blk),
        .req_ilv_i    (req_interleave),
        .bank_free_i  (bank_free),
        .finish_i     (finish),
        .busy_o       (busy),
        .mem_avalid_o (mem_avalid),
        .mem_addr_o   (mem_addr),
        .bank_start_o (bank_start)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        fill_bank_timer #(.LAT(ACCESS_LAT)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (bank_start[b]),
            .free_o  (bank_free[b])
        );
    end

    fill_collect #(.DATA_W(DATA_W), .WORDS(WORDS)) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .rvalid_i   (mem_rvalid),
        .rdata_i    (mem_rdata),
        .last_o     (finish),
        .blk_data_o (blk_data),
        .done_o     (done)
    );

    // R2
    addr_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_avalid |-> busy);

    // R7
    idle_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    start_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !done) |=> (busy && mem_avalid));
endmodule

// File: tb/fill_ctrl_tb.sv
module fill_ctrl_tb;
    localparam int BLK_W  = 20;
    localparam int DATA_W = 32;
    localparam int WORDS  = 8;
    localparam int LAT    = 20;
    localparam int AW     = BLK_W + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [BLK_W-1:0]  req_blk = '0;
    logic              req_interleave = 1'b0;
    logic              busy, mem_avalid, done;
    logic [AW-1:0]     mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [WORDS*DATA_W-1:0] blk_data;

    always #2.5 clk = ~clk;

    fill_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
        .req_interleave(req_interleave), .busy(busy), .mem_avalid(mem_avalid),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .blk_data(blk_data), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_cnt = 0;
    int exp_done_cyc = -1;
    logic [BLK_W-1:0] exp_blk = '0;
    logic done_prev = 1'b0;

    int            exp_cyc[$];
    logic [AW-1:0] exp_addr[$];
    int            ret_cyc[$];
    logic [AW-1:0] ret_addr[$];

    function automatic logic [DATA_W-1:0] mem_word(input logic [AW-1:0] a);
        return (DATA_W'(a) * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // memory model and monitor, both on the falling edge
    always @(negedge clk) begin
        if (ret_cyc.size() > 0 && ret_cyc[0] == cyc) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem_word(ret_addr[0]);
            void'(ret_cyc.pop_front());
            void'(ret_addr.pop_front());
        end else begin
            mem_rvalid <= 1'b0;
        end

        if (rst_n && mem_avalid) begin
            ret_cyc.push_back(cyc + LAT + 1);
            ret_addr.push_back(mem_addr);
            if (exp_cyc.size() == 0) begin
                check(1'b0, "R8", "unexpected address", mem_addr, 0);
            end else begin
                // R3 R4 R5 R9: address value and cycle of issue
                check(mem_addr == exp_addr[0], "R3", "address", mem_addr, exp_addr[0]);
                check(cyc == exp_cyc[0], "R4/R5", "issue cycle", cyc, exp_cyc[0]);
                void'(exp_cyc.pop_front());
                void'(exp_addr.pop_front());
            end
        end

        if (rst_n && done_prev) begin
            check(!done, "R7", "done width", done, 0);
        end
        if (rst_n && done) begin
            check(cyc == exp_done_cyc, "R10", "done cycle", cyc, exp_done_cyc);
            check(!busy, "R7", "busy in done cycle", busy, 0);
            check(exp_cyc.size() == 0, "R3", "addresses left", exp_cyc.size(), 0);
            for (int k = 0; k < WORDS; k++) begin
                check(blk_data[k*DATA_W +: DATA_W] == mem_word({exp_blk, 3'(k)}),
                      "R6", "block word", blk_data[k*DATA_W +: DATA_W],
                      mem_word({exp_blk, 3'(k)}));
            end
            done_cnt++;
        end
        done_prev <= done;
    end

    // driver: request one block and push its expected address schedule
    task automatic do_fill(input logic [BLK_W-1:0] blk, input bit ilv, input bit poke);
        int r;
        int n;
        n = done_cnt;
        r = cyc;
        req_blk        = blk;
        req_interleave = ilv;
        req_valid      = 1'b1;
        exp_blk        = blk;
        for (int k = 0; k < WORDS; k++) begin
            exp_addr.push_back({blk, 3'(k)});
            if (ilv) exp_cyc.push_back(r + 1 + (k % 4) + (k / 4) * (LAT + 1));
            else     exp_cyc.push_back(r + 1 + k * (LAT + 1));
        end
        exp_done_cyc = ilv ? r + 47 : r + 170;
        @(negedge clk);
        // R2: busy from the cycle after acceptance
        check(busy, "R2", "busy after accept", busy, 1);
        req_valid = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            // R8 R9: request and mode flip during a fill must be ignored
            req_blk        = ~blk;
            req_interleave = ~ilv;
            req_valid      = 1'b1;
            repeat (3) @(negedge clk);
            req_valid      = 1'b0;
        end
        wait (done_cnt == n + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !mem_avalid, "R1", "in reset", {busy, done, mem_avalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_avalid, "R1", "after reset", {busy, done, mem_avalid}, 0);
        do_fill(20'h00012, 1'b0, 1'b0);
        @(negedge clk);
        do_fill(20'h00ABC, 1'b1, 1'b0);
        @(negedge clk);
        do_fill(20'hFFFFF, 1'b1, 1'b1);
        @(negedge clk);
        do_fill(20'h5A5A5, 1'b0, 1'b1);
        // R7: new request issued in the done cycle itself
        do_fill(20'h00000, 1'b1, 1'b0);
        do_fill(20'h12345, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check(!busy && !mem_avalid, "R7", "idle at end", {busy, mem_avalid}, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule